// File: doc/BRIEF.md
# Multi-Way Sequential Stream Prefetch Buffer

This unit sits next to a first-level cache and keeps prefetched lines in a set of small FIFO buffers, one per tracked stream. Prefetched lines stay out of the cache. Each time the cache misses, it sends the missing line address here. The unit compares that address with the oldest entry, the head, of every buffer at once. When a head matches, the line goes back to the cache and that entry is removed. The buffer then has a free slot, so it goes on to fetch the next sequential line. When no head matches, the unit reports a miss, so the cache fetches the line itself. The least recently used buffer is then cleared and restarted at the line that follows the miss.

Toward memory, the unit issues line reads on a pipelined port. Several reads can be outstanding, and responses come back in the order they were requested. Each response is written into the buffer slot that issued it. If that buffer was restarted in the meantime, the response is dropped. Lookups are controlled by a two-state machine. IDLE accepts a miss. On a head match whose data is present, IDLE answers and stays in IDLE. On a miss, it restarts a buffer, answers and stays in IDLE. On a head match whose data is still in flight, IDLE moves to WAIT. WAIT holds off new misses until the awaited data lands, then answers and moves back to IDLE.

Top module: `stream_pf_top`

## Requirements
- R1: After reset, miss_ready is 1, resp_valid is 0 and mem_req_valid is 0, because no buffer is active.
- R2: When an accepted miss address matches no buffer head, the unit gives resp_valid=1 with resp_hit=0 one cycle after acceptance. It then restarts the least recently used buffer, which requests miss+1, miss+2 and so on in ascending order.
- R3: A buffer holds at most DEPTH lines (default 4), counting lines both in flight and present. A full buffer issues no further requests.
- R4: When a head matches and its data is present, the unit gives resp_valid=1, resp_hit=1 and resp_data equal to the returned line one cycle after acceptance. That entry is removed, and the buffer then requests the line after the last one it requested.
- R5: Several buffers follow independent sequential streams at the same time. Misses from those streams may be interleaved in any order, and each stream still hits.
- R6: Only the head of each buffer is compared with the miss address. A miss on a line that sits behind a head is answered with resp_hit=0.
- R7: When a head matches but its data is still in flight, miss_ready stays 0 until that data arrives. The response then carries that data, and the line is never requested a second time.
- R8: The buffer that is restarted is the one least recently used. Both a head hit and a restart count as a use.
- R9: Memory responses arrive in request order. A response whose buffer was restarted after it was requested is discarded and never reaches resp_data.
- R10: Up to OUTQ reads may be outstanding. A restarted buffer issues its requests on consecutive cycles without waiting for any response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Cache miss lookup request |
| miss_addr | input | AW | Line address of the miss |
| miss_ready | output | 1 | Lookup accepted this cycle when high together with miss_valid |
| resp_valid | output | 1 | Lookup answer valid, one-cycle pulse |
| resp_hit | output | 1 | 1: line supplied from a buffer, 0: not held |
| resp_data | output | DW | Line data when resp_hit is 1 |
| mem_req_valid | output | 1 | Line read request to memory |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Line address requested |
| mem_rsp_valid | input | 1 | Read data returning, in request order |
| mem_rsp_data | input | DW | Returned line data |

## Verification
The bench targets three corner cases.

- A buffer restarted while its old reads are still in flight. A design that does not discard those late responses writes old data into the new stream's slots, and a later hit returns the wrong line.
- A lookup that hits a head whose data is still in flight. A wrong design either answers at once with garbage or issues the same read twice.
- Lookups on a line sitting behind a head, and replacement order across four streams. Errors here show up as hits that should be misses, or as the wrong stream being evicted.

A memory model checks request addresses and their cycle spacing, so it catches a buffer that over-fills or stops short of its depth.

// File: rtl/pf_pkg.sv
package pf_pkg;
    typedef enum logic {
        S_IDLE = 1'b0,
        S_WAIT = 1'b1
    } pf_state_e;
endpackage

// File: rtl/pf_way.sv
module pf_way #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int SW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [AW-1:0] flush_addr,
    input  logic          pop,
    input  logic          alloc,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_slot,
    input  logic [DW-1:0] wr_data,
    output logic          want,
    output logic [AW-1:0] alloc_addr,
    output logic [SW-1:0] alloc_slot,
    output logic          head_valid,
    output logic          head_avail,
    output logic [AW-1:0] head_tag,
    output logic [DW-1:0] head_data
);
    logic [AW-1:0]    tag_q [DEPTH];
    logic [DW-1:0]    dat_q [DEPTH];
    logic [DEPTH-1:0] avl_q;
    logic [SW-1:0]    hd_q, tl_q;
    logic [SW:0]      cnt_q;
    logic             act_q;
    logic [AW-1:0]    nxt_q;

    function automatic logic [SW-1:0] step(input logic [SW-1:0] p);
        return (p == SW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign want       = act_q && (cnt_q < (SW+1)'(DEPTH));
    assign alloc_addr = nxt_q;
    assign alloc_slot = tl_q;
    assign head_valid = (cnt_q != '0);
    assign head_avail = head_valid && avl_q[hd_q];
    assign head_tag   = tag_q[hd_q];
    assign head_data  = dat_q[hd_q];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            nxt_q <= '0;
            hd_q  <= '0;
            tl_q  <= '0;
            cnt_q <= '0;
            avl_q <= '0;
            for (int i = 0; i < DEPTH; i++) tag_q[i] <= '0;
        end else if (flush) begin
            act_q <= 1'b1;
            nxt_q <= flush_addr;
            hd_q  <= '0;
            tl_q  <= '0;
            cnt_q <= '0;
            avl_q <= '0;
        end else begin
            if (alloc) begin
                tag_q[tl_q] <= nxt_q;
                avl_q[tl_q] <= 1'b0;
                tl_q        <= step(tl_q);
                nxt_q       <= nxt_q + 1'b1;
            end
            if (wr_en) avl_q[wr_slot] <= 1'b1;
            if (pop) hd_q <= step(hd_q);
            case ({alloc, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !flush) dat_q[wr_slot] <= wr_data;
    end

    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= (SW+1)'(DEPTH)); // R3
    AST_POP_READY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_avail); // R7
    AST_NO_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |-> !avl_q[wr_slot]); // R7
endmodule

// File: rtl/pf_lru.sv
module pf_lru #(
    parameter int NWAYS = 4,
    localparam int IW   = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch,
    input  logic [IW-1:0] touch_way,
    output logic [IW-1:0] victim
);
    logic [IW-1:0] age_q [NWAYS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NWAYS; w++) age_q[w] <= IW'(w);
        end else if (touch) begin
            for (int w = 0; w < NWAYS; w++) begin
                if (IW'(w) == touch_way)
                    age_q[w] <= '0;
                else if (age_q[w] < age_q[touch_way])
                    age_q[w] <= age_q[w] + 1'b1;
            end
        end
    end

    always_comb begin
        victim = '0;
        for (int w = 0; w < NWAYS; w++)
            if (age_q[w] == IW'(NWAYS - 1)) victim = IW'(w);
    end

    AST_LRU_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        touch |=> (victim != $past(touch_way))); // R8
endmodule

// File: rtl/pf_ordq.sv
module pf_ordq #(
    parameter int IW = 2,
    parameter int SW = 2,
    parameter int QD = 24,
    localparam int QW = (QD > 1) ? $clog2(QD) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [IW-1:0] push_way,
    input  logic [SW-1:0] push_slot,
    input  logic          pop,
    input  logic          kill,
    input  logic [IW-1:0] kill_way,
    output logic          full,
    output logic          empty,
    output logic [IW-1:0] hd_way,
    output logic [SW-1:0] hd_slot,
    output logic          hd_live
);
    logic [IW-1:0] way_q  [QD];
    logic [SW-1:0] slot_q [QD];
    logic [QD-1:0] live_q;
    logic [QW-1:0] rd_q, wr_q;
    logic [QW:0]   cnt_q;

    function automatic logic [QW-1:0] step(input logic [QW-1:0] p);
        return (p == QW'(QD - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt_q == (QW+1)'(QD));
    assign empty   = (cnt_q == '0);
    assign hd_way  = way_q[rd_q];
    assign hd_slot = slot_q[rd_q];
    assign hd_live = live_q[rd_q];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= '0;
            wr_q   <= '0;
            cnt_q  <= '0;
            live_q <= '0;
            for (int i = 0; i < QD; i++) begin
                way_q[i]  <= '0;
                slot_q[i] <= '0;
            end
        end else begin
            if (kill)
                for (int i = 0; i < QD; i++)
                    if (way_q[i] == kill_way) live_q[i] <= 1'b0;
            if (push) begin
                way_q[wr_q]  <= push_way;
                slot_q[wr_q] <= push_slot;
                live_q[wr_q] <= 1'b1;
                wr_q         <= step(wr_q);
            end
            if (pop) rd_q <= step(rd_q);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    AST_Q_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R10
    AST_Q_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R9
endmodule

// File: rtl/stream_pf_top.sv
module stream_pf_top
    import pf_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int NWAYS = 4,
    parameter int DEPTH = 4,
    parameter int OUTQ  = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          miss_valid,
    input  logic [AW-1:0] miss_addr,
    output logic          miss_ready,
    output logic          resp_valid,
    output logic          resp_hit,
    output logic [DW-1:0] resp_data,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data
);
    localparam int IW = (NWAYS > 1) ? $clog2(NWAYS) : 1;
    localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    pf_state_e     state_q;
    logic [IW-1:0] wait_q;

    logic [NWAYS-1:0] w_want, w_hv, w_av, w_pop, w_alloc, w_wr, w_flush, hit_vec, cand;
    logic [AW-1:0]    w_tag   [NWAYS];
    logic [DW-1:0]    w_data  [NWAYS];
    logic [AW-1:0]    w_aaddr [NWAYS];
    logic [SW-1:0]    w_aslot [NWAYS];

    logic          accept, hit_any, flush_en, fire, pop_any;
    logic [IW-1:0] hit_way, victim, req_way, sel_way, touch_way;
    logic          q_full, q_empty, q_live;
    logic [IW-1:0] q_way;
    logic [SW-1:0] q_slot;

    assign miss_ready = (state_q == S_IDLE);
    assign accept     = miss_ready && miss_valid;

    always_comb begin
        hit_way = '0;
        req_way = '0;
        for (int w = NWAYS - 1; w >= 0; w--) begin
            hit_vec[w] = w_hv[w] && (w_tag[w] == miss_addr);
            if (hit_vec[w]) hit_way = IW'(w);
        end
        hit_any   = |hit_vec;
        flush_en  = accept && !hit_any;
        touch_way = hit_any ? hit_way : victim;
        sel_way   = (state_q == S_WAIT) ? wait_q : hit_way;
        for (int w = NWAYS - 1; w >= 0; w--) begin
            w_flush[w] = flush_en && (victim == IW'(w));
            cand[w]    = w_want[w] && !w_flush[w];
            if (cand[w]) req_way = IW'(w);
        end
        mem_req_valid = (|cand) && !q_full;
        fire          = mem_req_valid && mem_req_ready;
        mem_req_addr  = w_aaddr[req_way];
        for (int w = 0; w < NWAYS; w++) begin
            w_alloc[w] = fire && (req_way == IW'(w));
            w_wr[w]    = mem_rsp_valid && q_live && (q_way == IW'(w));
            w_pop[w]   = (sel_way == IW'(w)) && w_av[w] &&
                         ((accept && hit_any) || (state_q == S_WAIT));
        end
        pop_any = |w_pop;
    end

    for (genvar g = 0; g < NWAYS; g++) begin : g_way
        pf_way #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_way (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (w_flush[g]),
            .flush_addr(miss_addr + 1'b1),
            .pop       (w_pop[g]),
            .alloc     (w_alloc[g]),
            .wr_en     (w_wr[g]),
            .wr_slot   (q_slot),
            .wr_data   (mem_rsp_data),
            .want      (w_want[g]),
            .alloc_addr(w_aaddr[g]),
            .alloc_slot(w_aslot[g]),
            .head_valid(w_hv[g]),
            .head_avail(w_av[g]),
            .head_tag  (w_tag[g]),
            .head_data (w_data[g])
        );
    end

    pf_lru #(.NWAYS(NWAYS)) u_lru (
        .clk      (clk),
        .rst_n    (rst_n),
        .touch    (accept),
        .touch_way(touch_way),
        .victim   (victim)
    );

    pf_ordq #(.IW(IW), .SW(SW), .QD(OUTQ)) u_ordq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (fire),
        .push_way (req_way),
        .push_slot(w_aslot[req_way]),
        .pop      (mem_rsp_valid),
        .kill     (flush_en),
        .kill_way (victim),
        .full     (q_full),
        .empty    (q_empty),
        .hd_way   (q_way),
        .hd_slot  (q_slot),
        .hd_live  (q_live)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            wait_q  <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (accept && hit_any && !w_av[hit_way]) begin
                    state_q <= S_WAIT;
                    wait_q  <= hit_way;
                end
                S_WAIT: if (w_av[wait_q]) state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // lookup answer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_data  <= '0;
        end else begin
            resp_valid <= pop_any || flush_en;
            resp_hit   <= pop_any;
            resp_data  <= pop_any ? w_data[sel_way] : '0;
        end
    end

    AST_RSP_HAS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> !q_empty); // R9
    AST_WAIT_NO_DUP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT && mem_req_valid) |-> (mem_req_addr != w_tag[wait_q])); // R7
    AST_WAIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT && !w_av[wait_q]) |=> !resp_valid); // R7
endmodule

// File: tb/sim_stream_pf_top.sv
module sim_stream_pf_top;
    localparam int AW = 16;
    localparam int DW = 32;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n, miss_valid, miss_ready, resp_valid, resp_hit;
    logic [AW-1:0] miss_addr, mem_req_addr;
    logic [DW-1:0] resp_data, mem_rsp_data;
    logic          mem_req_valid, mem_req_ready, mem_rsp_valid;

    stream_pf_top u0 (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .miss_ready(miss_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_data(resp_data), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    int checks = 0, fails = 0, cyc = 0, mem_lat = 6;
    bit done = 0;
    logic [AW-1:0] mq_addr [$];
    int            mq_due  [$];
    logic [AW-1:0] req_log [$];
    int            req_cyc [$];
    bit            exp_hit [$];
    logic [DW-1:0] exp_dat [$];
    string         exp_tag [$];

    function automatic logic [DW-1:0] line_of(input logic [AW-1:0] a);
        return {a, a ^ 16'hC3A5};
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // memory model: in-order, fixed latency
    initial begin
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        mem_req_ready = 1'b1;
        forever begin
            @(negedge clk); #2;
            cyc++;
            if (!rst_n) begin
                mq_addr.delete(); mq_due.delete();
                mem_rsp_valid = 1'b0;
            end else begin
                if (mem_req_valid && mem_req_ready) begin
                    mq_addr.push_back(mem_req_addr);
                    mq_due.push_back(cyc + mem_lat);
                    req_log.push_back(mem_req_addr);
                    req_cyc.push_back(cyc);
                end
                if (mq_due.size() > 0 && mq_due[0] <= cyc) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = line_of(mq_addr.pop_front());
                    void'(mq_due.pop_front());
                end else begin
                    mem_rsp_valid = 1'b0;
                end
            end
        end
    end

    // monitor: scoreboard compare
    initial forever begin
        @(negedge clk); #3;
        if (rst_n && resp_valid) begin
            if (exp_hit.size() == 0) begin
                check(1'b0, "unexpected response", resp_hit, 0);
            end else begin
                automatic bit            eh = exp_hit.pop_front();
                automatic logic [DW-1:0] ed = exp_dat.pop_front();
                automatic string         et = exp_tag.pop_front();
                check(resp_hit == eh, et, resp_hit, eh);
                if (eh) check(resp_data == ed, et, resp_data, ed);
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_miss(input logic [AW-1:0] a, input bit hit, input string tag);
        @(negedge clk);
        while (!miss_ready) @(negedge clk);
        miss_valid = 1'b1;
        miss_addr  = a;
        exp_hit.push_back(hit);
        exp_dat.push_back(line_of(a));
        exp_tag.push_back(tag);
        @(negedge clk);
        miss_valid = 1'b0;
    endtask

    task automatic drain;
        for (int i = 0; i < 400 && exp_hit.size() != 0; i++) @(negedge clk);
        check(exp_hit.size() == 0, "response count", exp_hit.size(), 0);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        miss_valid = 1'b0;
        miss_addr  = '0;
        wait_cyc(3);
        req_log.delete(); req_cyc.delete();
        exp_hit.delete(); exp_dat.delete(); exp_tag.delete();
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        // R1 reset state
        do_reset();
        #3;
        check(miss_ready == 1'b1, "R1 miss_ready", miss_ready, 1);
        check(resp_valid == 1'b0, "R1 resp_valid", resp_valid, 0);
        check(mem_req_valid == 1'b0, "R1 mem_req_valid", mem_req_valid, 0);

        // R2 / R3 / R10: restart and bounded sequential fetch
        do_miss(16'h0100, 0, "R2 cold miss");
        wait_cyc(20);
        check(req_log.size() == 4, "R3 depth bound", req_log.size(), 4);
        for (int i = 0; i < 4 && i < req_log.size(); i++)
            check(req_log[i] == 16'h0101 + i, "R2 sequential address", req_log[i], 16'h0101 + i);
        if (req_cyc.size() >= 4)
            check(req_cyc[3] - req_cyc[0] == 3, "R10 back-to-back", req_cyc[3] - req_cyc[0], 3);
        // R4 head hit and refill
        do_miss(16'h0101, 1, "R4 head hit");
        drain();
        wait_cyc(20);
        check(req_log.size() == 5, "R4 refill count", req_log.size(), 5);
        if (req_log.size() >= 5)
            check(req_log[4] == 16'h0105, "R4 refill address", req_log[4], 16'h0105);
        // R6 behind-head is a miss; original head still hits
        do_miss(16'h0103, 0, "R6 non-head");
        do_miss(16'h0102, 1, "R6 head after");
        drain();

        // R5 interleaved streams
        do_reset();
        do_miss(16'h0200, 0, "R5 start a");
        do_miss(16'h0300, 0, "R5 start b");
        do_miss(16'h0400, 0, "R5 start c");
        wait_cyc(40);
        do_miss(16'h0201, 1, "R5 a1");
        do_miss(16'h0301, 1, "R5 b1");
        do_miss(16'h0202, 1, "R5 a2");
        do_miss(16'h0401, 1, "R5 c1");
        do_miss(16'h0302, 1, "R5 b2");
        do_miss(16'h0203, 1, "R5 a3");
        do_miss(16'h0204, 1, "R5 a4");
        wait_cyc(20);
        do_miss(16'h0205, 1, "R5 a5");
        drain();

        // R7 hit on in-flight head
        do_reset();
        do_miss(16'h0500, 0, "R7 start");
        wait_cyc(2);
        do_miss(16'h0501, 1, "R7 stalled hit");
        #3;
        check(miss_ready == 1'b0, "R7 stall", miss_ready, 0);
        drain();
        wait_cyc(20);
        n = 0;
        foreach (req_log[i]) if (req_log[i] == 16'h0501) n++;
        check(n == 1, "R7 single request", n, 1);

        // R8 replacement order
        do_reset();
        do_miss(16'h1000, 0, "R8 a");
        do_miss(16'h2000, 0, "R8 b");
        do_miss(16'h3000, 0, "R8 c");
        do_miss(16'h4000, 0, "R8 d");
        wait_cyc(30);
        do_miss(16'h1001, 1, "R8 touch a");
        do_miss(16'h2001, 1, "R8 touch b");
        do_miss(16'h3001, 1, "R8 touch c");
        do_miss(16'h5000, 0, "R8 evict d");
        wait_cyc(30);
        do_miss(16'h4001, 0, "R8 d gone");
        do_miss(16'h2002, 1, "R8 b kept");
        do_miss(16'h1002, 0, "R8 a evicted");
        drain();

        // R9 stale responses after restart
        do_reset();
        mem_lat = 40;
        do_miss(16'h0010, 0, "R9 s1");
        wait_cyc(3);
        do_miss(16'h0020, 0, "R9 s2");
        do_miss(16'h0030, 0, "R9 s3");
        do_miss(16'h0040, 0, "R9 s4");
        do_miss(16'h0050, 0, "R9 restart s1");
        wait_cyc(36);
        do_miss(16'h0051, 1, "R9 fresh data");
        do_miss(16'h0052, 1, "R9 fresh data next");
        drain();
        mem_lat = 6;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule